// File: doc/BRIEF.md
# Shader Attribute Store Unit

This block accepts one attribute-store request at a time and expands it into a train of 32-bit word writes aimed at an attribute memory of `NUM_ATTR` words. A request names an operation size (one to four words), a patch-section flag, a base register value, an 11-bit immediate, an indicator that the base register is the zero register, a data-register index and the data words themselves. From these the block picks an addressing mode, aligns both the byte address and the register index to the operation size, and then walks the words one per clock cycle.

For each word the block decides whether the write is committed or silently dropped. Non-patch writes need an output-mask bit that is set together with either the next-stage input-mask bit or the store-request bit at that word. Every word, patch or not, must fall inside the byte window 0 to 1023. A committed word raises `wr_en` with the word index, register index and data. A dropped word raises `wr_drop` instead. The request side uses a valid/ready handshake. Ready stays low while a request's words are being issued.

Top module: `attr_store_unit`

## Requirements
- R1: The size code 0, 1, 2, 3 produces exactly 1, 2, 3, 4 word events (each a `wr_en` or a `wr_drop`) in consecutive cycles. Event k carries word index `start/4 + k` and data `req_data[32k+31:32k]`.
- R2: When `req_base_zero` is 1, the byte address is the unsigned value of `req_imm[9:0]`, whatever the patch flag and `req_imm[10]` are.
- R3: When `req_base_zero` is 0 and `req_patch` is 1, the byte address is the signed 32-bit `req_base` plus the sign-extended 11-bit `req_imm`.
- R4: When `req_base_zero` is 0, `req_patch` is 0 and `req_imm` is 0 (indexed physical mode), the byte address is the signed `req_base` value itself.
- R5: When `req_base_zero` is 0, `req_patch` is 0 and `req_imm` is not 0, the encoding is invalid. Every word of the request is dropped.
- R6: Before word expansion, the byte address has its low 2 bits cleared for size 0, its low 3 bits for size 1 and its low 4 bits for sizes 2 and 3.
- R7: The register index has bit 0 cleared for size 1 and bits 1:0 cleared for sizes 2 and 3, and is unchanged for size 0. Word k reports the aligned index plus k on `wr_reg_idx` (modulo 256).
- R8: A non-patch word at word index w commits only if `out_mask[w]` and (`next_in_mask[w]` or `store_req_mask[w]`). Otherwise it is dropped.
- R9: A word whose byte address is negative or at least 1024 is dropped, in both patch and non-patch stores.
- R10: A patch word in range commits whatever the three mask vectors hold, and reports `wr_patch` = 1.
- R11: `req_ready` is 1 when idle. A request accepted at a clock edge shows its first word in the next cycle. `req_ready` stays 0 for exactly as many cycles as the request has words.
- R12: In any cycle at most one of `wr_en` and `wr_drop` is high. Neither is high outside a request's word cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_size | input | 2 | Word count minus one (0: 32 bit, 3: 128 bit) |
| req_patch | input | 1 | Store goes to the patch section |
| req_base_zero | input | 1 | Base register is the zero register or absent |
| req_base | input | 32 | Base register value, signed |
| req_imm | input | 11 | Immediate offset |
| req_reg_idx | input | 8 | First data-register index before alignment |
| req_data | input | 128 | Data words, word k in bits 32k+31:32k |
| out_mask | input | 256 | Current-stage output mask, one bit per word |
| next_in_mask | input | 256 | Next-stage input mask, one bit per word |
| store_req_mask | input | 256 | Store-request mask, one bit per word |
| wr_en | output | 1 | Word committed this cycle |
| wr_drop | output | 1 | Word dropped this cycle |
| wr_patch | output | 1 | Current word targets the patch section |
| wr_addr | output | 8 | Word index of a committed word |
| wr_reg_idx | output | 8 | Data-register index of the current word |
| wr_data | output | 32 | Data of the current word |

## Verification
Stores are sent in each addressing mode with addresses that are deliberately misaligned, so that immediate, patch-indexed and physical addressing are only told apart when the aligned word index comes out right. Mask patterns that set the three vectors in different combinations over the four words of a single vector store separate the output-mask term from the OR of the other two. The same zero masks under a patch store show that the mask is bypassed there. Addresses just inside and just outside the 1024-byte window, reached through negative offsets and large base values, exercise the range filter. An invalid encoding and back-to-back requests check the drop path and the handshake timing.

// File: rtl/attr_store_pkg.sv
package attr_store_pkg;

  typedef enum logic [1:0] {
    MODE_IMM       = 2'd0,
    MODE_PATCH_IDX = 2'd1,
    MODE_PHYS      = 2'd2,
    MODE_BAD       = 2'd3
  } addr_mode_e;

  // number of 32-bit words moved by a size code
  function automatic logic [2:0] f_word_count(input logic [1:0] sz);
    return {1'b0, sz} + 3'd1;
  endfunction

  // byte-address bits cleared for alignment
  function automatic int unsigned f_addr_lsbs(input logic [1:0] sz);
    case (sz)
      2'd0:    return 2;
      2'd1:    return 3;
      default: return 4;
    endcase
  endfunction

  // register-index bits cleared for alignment
  function automatic int unsigned f_reg_lsbs(input logic [1:0] sz);
    case (sz)
      2'd0:    return 0;
      2'd1:    return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/attr_addr_gen.sv
module attr_addr_gen
  import attr_store_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int IMM_W  = 11,
  parameter int REG_W  = 8,
  parameter int CALC_W = BASE_W + 2
) (
  input  logic [1:0]              size,
  input  logic                    patch,
  input  logic                    base_zero,
  input  logic [BASE_W-1:0]       base,
  input  logic [IMM_W-1:0]        imm,
  input  logic [REG_W-1:0]        reg_idx,
  output addr_mode_e              mode,
  output logic signed [CALC_W-1:0] start_addr,
  output logic [REG_W-1:0]        reg_start,
  output logic [2:0]              nwords
);

  localparam int ALIGN_MAX = 4;

  function automatic logic [CALC_W-1:0] f_clear_addr(input logic [CALC_W-1:0] a,
                                                      input int unsigned n);
    logic [CALC_W-1:0] r;
    r = a;
    for (int i = 0; i < ALIGN_MAX; i++)
      if (i < int'(n)) r[i] = 1'b0;
    return r;
  endfunction

  function automatic logic [REG_W-1:0] f_clear_reg(input logic [REG_W-1:0] a,
                                                    input int unsigned n);
    logic [REG_W-1:0] r;
    r = a;
    for (int i = 0; i < 2; i++)
      if (i < int'(n)) r[i] = 1'b0;
    return r;
  endfunction

  logic signed [CALC_W-1:0] base_s;
  logic signed [CALC_W-1:0] imm_s;
  logic signed [CALC_W-1:0] imm_u;
  logic signed [CALC_W-1:0] raw_addr;

  assign base_s = {{(CALC_W-BASE_W){base[BASE_W-1]}}, base};
  assign imm_s  = {{(CALC_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_u  = {{(CALC_W-IMM_W+1){1'b0}}, imm[IMM_W-2:0]};

  always_comb begin
    if (base_zero)          mode = MODE_IMM;
    else if (patch)         mode = MODE_PATCH_IDX;
    else if (imm == '0)     mode = MODE_PHYS;
    else                    mode = MODE_BAD;
  end

  always_comb begin
    case (mode)
      MODE_IMM:       raw_addr = imm_u;
      MODE_PATCH_IDX: raw_addr = base_s + imm_s;
      MODE_PHYS:      raw_addr = base_s;
      default:        raw_addr = base_s;
    endcase
  end

  assign start_addr = f_clear_addr(raw_addr, f_addr_lsbs(size));
  assign reg_start  = f_clear_reg(reg_idx, f_reg_lsbs(size));
  assign nwords     = f_word_count(size);

endmodule

// File: rtl/attr_word_filter.sv
module attr_word_filter #(
  parameter int CALC_W   = 34,
  parameter int NUM_ATTR = 256,
  parameter int WIDX_W   = $clog2(NUM_ATTR)
) (
  input  logic signed [CALC_W-1:0] word_addr,
  input  logic                     patch,
  input  logic                     bad,
  input  logic [NUM_ATTR-1:0]      out_mask,
  input  logic [NUM_ATTR-1:0]      next_in_mask,
  input  logic [NUM_ATTR-1:0]      store_req_mask,
  output logic [WIDX_W-1:0]        widx,
  output logic                     in_range,
  output logic                     mask_ok,
  output logic                     commit
);

  localparam logic signed [CALC_W-1:0] BYTE_LIMIT = CALC_W'(NUM_ATTR * 4);

  function automatic logic f_window(input logic signed [CALC_W-1:0] a);
    return (a >= 0) && (a < BYTE_LIMIT);
  endfunction

  function automatic logic f_mask_rule(input logic o, input logic n, input logic s);
    return o & (n | s);
  endfunction

  assign widx     = word_addr[WIDX_W+1:2];
  assign in_range = f_window(word_addr);
  assign mask_ok  = patch | f_mask_rule(out_mask[widx], next_in_mask[widx],
                                        store_req_mask[widx]);
  assign commit   = !bad && in_range && mask_ok;

endmodule

// File: rtl/attr_store_seq.sv
module attr_store_seq #(
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 4,
  parameter int REG_W     = 8,
  parameter int CALC_W    = 34,
  parameter int CNT_W     = $clog2(MAX_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic signed [CALC_W-1:0]    start_addr,
  input  logic [REG_W-1:0]            reg_start,
  input  logic [2:0]                  nwords,
  input  logic                        patch,
  input  logic                        bad,
  input  logic [MAX_WORDS*DATA_W-1:0] data,
  output logic                        issue,
  output logic signed [CALC_W-1:0]    word_addr,
  output logic [REG_W-1:0]            word_reg,
  output logic [DATA_W-1:0]           word_data,
  output logic                        word_patch,
  output logic                        word_bad
);

  logic                     busy;
  logic [CNT_W-1:0]         cnt;
  logic [CNT_W-1:0]         last_q;
  logic signed [CALC_W-1:0] addr_q;
  logic [REG_W-1:0]         reg_q;
  logic                     patch_q;
  logic                     bad_q;
  logic [DATA_W-1:0]        data_q [MAX_WORDS];
  logic [2:0]               nm1;
  logic                     accept;

  assign accept    = req_valid && !busy;
  assign req_ready = !busy;
  assign nm1       = nwords - 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      last_q  <= '0;
      addr_q  <= '0;
      reg_q   <= '0;
      patch_q <= 1'b0;
      bad_q   <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      cnt     <= '0;
      last_q  <= nm1[CNT_W-1:0];
      addr_q  <= start_addr;
      reg_q   <= reg_start;
      patch_q <= patch;
      bad_q   <= bad;
    end else if (busy) begin
      if (cnt == last_q) busy <= 1'b0;
      else               cnt  <= cnt + 1'b1;
    end
  end

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_data
    always_ff @(posedge clk) begin
      if (!rst_n)      data_q[w] <= '0;
      else if (accept) data_q[w] <= data[w*DATA_W +: DATA_W];
    end
  end

  assign issue      = busy;
  assign word_addr  = addr_q + (CALC_W'(cnt) << 2);
  assign word_reg   = reg_q + REG_W'(cnt);
  assign word_data  = data_q[cnt];
  assign word_patch = patch_q;
  assign word_bad   = bad_q;

endmodule

// File: rtl/attr_store_unit.sv
module attr_store_unit
  import attr_store_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BASE_W    = 32,
  parameter int IMM_W     = 11,
  parameter int REG_W     = 8,
  parameter int NUM_ATTR  = 256,
  parameter int MAX_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [1:0]                  req_size,
  input  logic                        req_patch,
  input  logic                        req_base_zero,
  input  logic [BASE_W-1:0]           req_base,
  input  logic [IMM_W-1:0]            req_imm,
  input  logic [REG_W-1:0]            req_reg_idx,
  input  logic [MAX_WORDS*DATA_W-1:0] req_data,
  input  logic [NUM_ATTR-1:0]         out_mask,
  input  logic [NUM_ATTR-1:0]         next_in_mask,
  input  logic [NUM_ATTR-1:0]         store_req_mask,
  output logic                        wr_en,
  output logic                        wr_drop,
  output logic                        wr_patch,
  output logic [$clog2(NUM_ATTR)-1:0] wr_addr,
  output logic [REG_W-1:0]            wr_reg_idx,
  output logic [DATA_W-1:0]           wr_data
);

  localparam int CALC_W = BASE_W + 2;
  localparam int WIDX_W = $clog2(NUM_ATTR);

  addr_mode_e               mode;
  logic signed [CALC_W-1:0] start_addr;
  logic [REG_W-1:0]         reg_start;
  logic [2:0]               nwords;
  logic                     issue;
  logic signed [CALC_W-1:0] word_addr;
  logic                     word_bad;
  logic                     word_in_range;
  logic                     word_mask_ok;
  logic                     word_commit;

  attr_addr_gen #(
    .BASE_W(BASE_W), .IMM_W(IMM_W), .REG_W(REG_W), .CALC_W(CALC_W)
  ) i_addr_gen (
    .size(req_size), .patch(req_patch), .base_zero(req_base_zero),
    .base(req_base), .imm(req_imm), .reg_idx(req_reg_idx),
    .mode(mode), .start_addr(start_addr), .reg_start(reg_start), .nwords(nwords)
  );

  attr_store_seq #(
    .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .REG_W(REG_W), .CALC_W(CALC_W)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .start_addr(start_addr), .reg_start(reg_start), .nwords(nwords),
    .patch(req_patch), .bad(mode == MODE_BAD), .data(req_data),
    .issue(issue), .word_addr(word_addr), .word_reg(wr_reg_idx),
    .word_data(wr_data), .word_patch(wr_patch), .word_bad(word_bad)
  );

  attr_word_filter #(
    .CALC_W(CALC_W), .NUM_ATTR(NUM_ATTR), .WIDX_W(WIDX_W)
  ) i_filter (
    .word_addr(word_addr), .patch(wr_patch), .bad(word_bad),
    .out_mask(out_mask), .next_in_mask(next_in_mask),
    .store_req_mask(store_req_mask), .widx(wr_addr),
    .in_range(word_in_range), .mask_ok(word_mask_ok), .commit(word_commit)
  );

  assign wr_en   = issue && word_commit;
  assign wr_drop = issue && !word_commit;

endmodule

// File: rtl/attr_store_chk.sv
module attr_store_chk #(
  parameter int NUM_ATTR = 256,
  parameter int WIDX_W   = $clog2(NUM_ATTR)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                wr_en,
  input logic                wr_drop,
  input logic                wr_patch,
  input logic [WIDX_W-1:0]   wr_addr,
  input logic [NUM_ATTR-1:0] out_mask,
  input logic [NUM_ATTR-1:0] next_in_mask,
  input logic [NUM_ATTR-1:0] store_req_mask,
  input logic                word_in_range,
  input logic                word_bad
);

  // R12
  no_dual_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_drop));

  // R11
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || wr_drop) |-> !req_ready);

  // R11
  first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (wr_en || wr_drop));

  // R8
  mask_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_patch) |->
      (out_mask[wr_addr] && (next_in_mask[wr_addr] || store_req_mask[wr_addr])));

  // R9
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> word_in_range);

  // R5
  bad_encoding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_bad |-> !wr_en);

  // R1
  consecutive_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || wr_drop) && $past(wr_en || wr_drop)) |->
      (wr_addr == $past(wr_addr) + 1'b1));

endmodule

bind attr_store_unit attr_store_chk #(.NUM_ATTR(NUM_ATTR)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .wr_en(wr_en), .wr_drop(wr_drop), .wr_patch(wr_patch), .wr_addr(wr_addr),
  .out_mask(out_mask), .next_in_mask(next_in_mask),
  .store_req_mask(store_req_mask), .word_in_range(word_in_range),
  .word_bad(word_bad)
);

// File: tb/test_attr_store_unit.sv
module test_attr_store_unit;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          commit;
    int          widx;
    logic [31:0] data;
    int          regi;
    bit          patch;
    string       tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_size = '0;
  logic         req_patch = 1'b0;
  logic         req_base_zero = 1'b1;
  logic [31:0]  req_base = '0;
  logic [10:0]  req_imm = '0;
  logic [7:0]   req_reg_idx = '0;
  logic [127:0] req_data = '0;
  logic [255:0] out_mask = '1;
  logic [255:0] next_in_mask = '1;
  logic [255:0] store_req_mask = '0;
  logic         wr_en, wr_drop, wr_patch;
  logic [7:0]   wr_addr, wr_reg_idx;
  logic [31:0]  wr_data;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t exp_q[$];
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  attr_store_unit i_attr_store_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_patch(req_patch), .req_base_zero(req_base_zero),
    .req_base(req_base), .req_imm(req_imm), .req_reg_idx(req_reg_idx),
    .req_data(req_data), .out_mask(out_mask), .next_in_mask(next_in_mask),
    .store_req_mask(store_req_mask), .wr_en(wr_en), .wr_drop(wr_drop),
    .wr_patch(wr_patch), .wr_addr(wr_addr), .wr_reg_idx(wr_reg_idx),
    .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // driver: model the request, queue expected words, drive the handshake
  task automatic send(input string tag, input logic [1:0] sz, input bit patch,
                      input bit bzero, input logic [31:0] base,
                      input logic [10:0] imm, input logic [7:0] regi,
                      input logic [127:0] data);
    longint raw, al;
    int     n, rl, lowc, rbase;
    bit     bad;
    n   = int'(sz) + 1;
    bad = 1'b0;
    if (bzero)           raw = longint'(imm[9:0]);
    else if (patch)      raw = longint'($signed(base)) + longint'($signed(imm));
    else if (imm == 0)   raw = longint'($signed(base));
    else begin           raw = longint'($signed(base)); bad = 1'b1; end
    al    = (sz == 2'd0) ? (raw & ~longint'(3)) :
            (sz == 2'd1) ? (raw & ~longint'(7)) : (raw & ~longint'(15));
    rl    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    rbase = int'(regi) - (int'(regi) % rl);
    for (int k = 0; k < n; k++) begin
      exp_t   e;
      longint a;
      bit     inr, mok;
      a   = al + 4 * k;
      inr = (a >= 0) && (a < 1024);
      e.widx = inr ? int'(a / 4) : 0;
      mok = patch || (out_mask[e.widx] &&
                      (next_in_mask[e.widx] || store_req_mask[e.widx]));
      e.commit = !bad && inr && mok;
      e.data   = data[32*k +: 32];
      e.regi   = (rbase + k) % 256;
      e.patch  = patch;
      e.tag    = tag;
      exp_q.push_back(e);
    end
    while (!req_ready) @(negedge clk);
    req_size = sz; req_patch = patch; req_base_zero = bzero; req_base = base;
    req_imm = imm; req_reg_idx = regi; req_data = data; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lowc = 0;
    while (!req_ready && lowc < 20) begin
      lowc++;
      @(negedge clk);
    end
    // R11: ready low for exactly the word count
    check(lowc == n, "R11", "ready-low cycles", lowc, n);
  endtask

  // monitor: pop and compare every word event
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (wr_en || wr_drop)) begin
        // R12: one kind of event per cycle
        check(!(wr_en && wr_drop), "R12", "en and drop together", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R12", "unexpected word event", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(wr_en == e.commit, e.tag, "commit", wr_en, e.commit);
          if (e.commit) begin
            check(int'(wr_addr) == e.widx, e.tag, "word index", wr_addr, e.widx);
            check(wr_data == e.data, e.tag, "data", wr_data, e.data);
            check(int'(wr_reg_idx) == e.regi, e.tag, "reg index", wr_reg_idx, e.regi);
            check(wr_patch == e.patch, e.tag, "patch flag", wr_patch, e.patch);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  localparam logic [127:0] D0 = 128'h44444444_33333333_22222222_11111111;
  localparam logic [127:0] D1 = 128'hDEAD0004_BEEF0003_CAFE0002_F00D0001;

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    check(wr_en == 1'b0 && wr_drop == 1'b0, "R12", "no event in reset", wr_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R1: immediate mode single word
    send("R2", 2'd0, 1'b0, 1'b1, 32'h0, 11'h040, 8'd3, D0);
    // R6, R1: misaligned immediate vector store
    send("R6", 2'd3, 1'b0, 1'b1, 32'h0, 11'h047, 8'd5, D1);
    // R9: top of the window, still in range
    send("R9", 2'd1, 1'b0, 1'b1, 32'h0, 11'h3FF, 8'd2, D0);
    // R2: bit 10 of the immediate ignored, patch with zero base
    out_mask = '0; next_in_mask = '0;
    send("R2", 2'd2, 1'b1, 1'b1, 32'h0, 11'h7F0, 8'd9, D1);
    // R10: patch indexed with negative offset, masks all zero
    send("R10", 2'd0, 1'b1, 1'b0, 32'h100, 11'h7FC, 8'd1, D0);
    // R3: patch indexed misaligned
    send("R3", 2'd1, 1'b1, 1'b0, 32'h20, 11'h00D, 8'd7, D1);
    // R9: negative patch address and beyond the window
    send("R9", 2'd0, 1'b1, 1'b0, 32'h8, 11'h7F0, 8'd0, D0);
    send("R9", 2'd3, 1'b1, 1'b0, 32'h3F0, 11'h010, 8'd0, D0);
    send("R9", 2'd1, 1'b0, 1'b0, 32'hFFFF_FFF0, 11'h0, 8'd0, D0);
    // R4: physical mode
    out_mask = '1; next_in_mask = '1;
    send("R4", 2'd0, 1'b0, 1'b0, 32'h84, 11'h0, 8'd4, D0);
    send("R4", 2'd2, 1'b0, 1'b0, 32'h3F4, 11'h0, 8'd6, D1);
    // R5: invalid encoding drops everything
    send("R5", 2'd3, 1'b0, 1'b0, 32'h40, 11'h005, 8'd0, D1);
    // R7: register alignment for each size
    send("R7", 2'd0, 1'b0, 1'b1, 32'h0, 11'h010, 8'd7, D0);
    send("R7", 2'd1, 1'b0, 1'b1, 32'h0, 11'h010, 8'd7, D0);
    send("R7", 2'd2, 1'b0, 1'b1, 32'h0, 11'h010, 8'd7, D1);
    send("R7", 2'd3, 1'b0, 1'b1, 32'h0, 11'h010, 8'd255, D1);
    // R8: mask combinations across words 16..19
    out_mask = '0; next_in_mask = '0; store_req_mask = '0;
    out_mask[16] = 1'b1; out_mask[18] = 1'b1; out_mask[19] = 1'b0;
    next_in_mask[16] = 1'b1; next_in_mask[17] = 1'b1;
    store_req_mask[18] = 1'b1; store_req_mask[19] = 1'b1;
    send("R8", 2'd3, 1'b0, 1'b1, 32'h0, 11'h040, 8'd0, D0);
    send("R8", 2'd3, 1'b0, 1'b0, 32'h40, 11'h0, 8'd8, D1);
    // R10: same masks, patch store commits all words
    send("R10", 2'd3, 1'b1, 1'b1, 32'h0, 11'h040, 8'd0, D1);
    // R1: back-to-back requests
    out_mask = '1; next_in_mask = '1;
    send("R1", 2'd1, 1'b0, 1'b1, 32'h0, 11'h100, 8'd10, D0);
    send("R1", 2'd2, 1'b0, 1'b1, 32'h0, 11'h200, 8'd12, D1);

    repeat (3) @(negedge clk);
    // R1: every expected word was produced
    check(exp_q.size() == 0, "R1", "words left unseen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule